// File: doc/BRIEF.md
# Byte DMA Channel with Up-Counting Length

This block is a single byte-wide DMA channel that sits between a disk controller's data path and system memory. Software sets a transfer length as a negative 16-bit number that climbs toward zero, an 18-bit byte address spread over three byte registers, and a control byte that picks the direction, starts the channel and enables three interrupt causes. Once running, every request from the peripheral moves one byte through a simple request/acknowledge memory port. The address and count each advance by one per byte.

The channel stops by itself when the count wraps to zero, or when memory answers an access with an error. A status byte records busy, terminal count, memory fault and a device interrupt forwarded from the disk controller. It also holds three mirrored control bits and a free software flag. One level interrupt output combines the three recorded causes, each gated by its own enable.

Top module: `dmx_channel`

## Requirements
- R1: After reset, status (offset 9) reads 0x70, count reads 0x0001 (offset A low byte, B high byte), the address bytes (offsets C, D, E) read 0, offset 8 reads 0 and irq is low.
- R2: Writing control (offset 8) copies data bits 6..4 into status bits 6..4. When data bit 0 (run) is set, status bit 7 (busy) sets. When bit 0 is clear, busy is left unchanged. Control bit 4 selects the direction: 1 moves bytes from the peripheral to memory.
- R3: With direction 1, each peripheral request while busy produces one memory write of the peripheral byte at the current address. The peripheral is acknowledged once the memory acknowledges, and the request and address hold until then.
- R4: With direction 0, each peripheral request while busy produces one memory read at the current address. The byte read is returned to the peripheral together with a one-cycle acknowledge.
- R5: Each byte moved adds one to both the count and the address. Both read back their current values during a transfer. The number of bytes moved is 0x10000 minus the programmed count.
- R6: When the count wraps to zero, status bit 3 (terminal count) sets, busy and run clear, and later peripheral requests start no memory access.
- R7: A memory error response aborts the transfer: busy and run clear, status bit 2 (fault) sets, and neither count nor address advances for that byte.
- R8: A pulse on dev_int sets status bit 1.
- R9: irq is high exactly while (status bit 3 and control bit 3) or (status bit 2 and control bit 2) or (status bit 1 and control bit 1) holds.
- R10: A write to status (offset 9) loads bits 7 and 3..0 from the data and leaves bits 6..4 unchanged.
- R11: A count write that leaves the count nonzero clears terminal count. A write that leaves it zero does not.
- R12: Writes to the count and address bytes are ignored while busy or while a memory access is in flight.
- R13: The address is 18 bits wide. Offset E holds bits 17..16, and an increment carries from the high byte into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| periph_req | input | 1 | Peripheral asks to move one byte |
| periph_wdata | input | DW | Byte from the peripheral (direction 1) |
| periph_ack | output | 1 | One-cycle acknowledge of the moved byte |
| periph_rdata | output | DW | Byte for the peripheral (direction 0), valid with periph_ack |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADR_W | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory completed the access |
| mem_err | input | 1 | Memory failed the access |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| dev_int | input | 1 | Device interrupt request pulse |
| irq | output | 1 | Combined interrupt level |

## Verification
The hardest case to reach is an abort partway through a transfer, with a memory error on one chosen byte. The counters must then show that only the bytes before it advanced. The bench's memory model compares every access address against an armed fault address, so the error lands on the second byte of a longer transfer. The wrap into the 2-bit extension is reached by starting the address two bytes below the 64 KiB boundary, in the same run that ends on terminal count.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    // register offsets on the 4-bit register port
    localparam logic [3:0] OFS_CTRL = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'h9;
    localparam logic [3:0] OFS_CNT  = 4'hA;  // first count lane
    localparam logic [3:0] OFS_ADR  = 4'hC;  // first address lane

    // control bit positions
    localparam int C_RUN    = 0;
    localparam int C_DEV_IE = 1;
    localparam int C_TMO_IE = 2;
    localparam int C_TC_IE  = 3;
    localparam int C_DIR    = 4;

    typedef enum logic {ENG_IDLE, ENG_XFER} eng_state_e;
endpackage

// File: rtl/dmx_ptr.sv
module dmx_ptr #(
    parameter int             W     = 16,
    parameter int             LANES = (W + 7) / 8,
    parameter logic [W-1:0]   RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_we,
    input  logic [7:0]       wdata,
    input  logic             inc,
    output logic [W-1:0]     val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        for (int b = 0; b < W; b++) begin
            if (lane_we[b / 8]) val_d[b] = wdata[b % 8];
        end
        if (inc) val_d = val_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine import dmx_pkg::*; #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dir_to_mem,
    input  logic          periph_req,
    input  logic [DW-1:0] periph_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          periph_ack,
    output logic [DW-1:0] periph_rdata,
    output logic          step,
    output logic          fault,
    output logic          active
);
    typedef struct packed {
        eng_state_e    st;
        logic          we;
        logic [DW-1:0] hold;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        step  = 1'b0;
        fault = 1'b0;
        case (eng_q.st)
            ENG_IDLE: begin
                if (go && periph_req) begin
                    eng_d.st   = ENG_XFER;
                    eng_d.we   = dir_to_mem;
                    eng_d.hold = periph_wdata;
                end
            end
            ENG_XFER: begin
                if (mem_err) begin
                    fault    = 1'b1;
                    eng_d.st = ENG_IDLE;
                end else if (mem_ack) begin
                    step     = 1'b1;
                    eng_d.st = ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, we: 1'b0, hold: '0};
        else        eng_q <= eng_d;
    end

    assign mem_req      = (eng_q.st == ENG_XFER);
    assign mem_we       = eng_q.we;
    assign mem_wdata    = eng_q.hold;
    assign periph_ack   = step;
    assign periph_rdata = mem_rdata;
    assign active       = mem_req;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_wdata))); // R3

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack); // R4
endmodule

// File: rtl/dmx_channel.sv
module dmx_channel import dmx_pkg::*; #(
    parameter int DW    = 8,
    parameter int CNT_W = 16,
    parameter int ADR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             periph_req,
    input  logic [DW-1:0]    periph_wdata,
    output logic             periph_ack,
    output logic [DW-1:0]    periph_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [ADR_W-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             dev_int,
    output logic             irq
);
    localparam int CNT_LANES = (CNT_W + 7) / 8;
    localparam int ADR_LANES = (ADR_W + 7) / 8;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [2:0] mirror;
        logic       busy;
        logic       tc;
        logic       tmo;
        logic       dint;
        logic       odd;
    } csr_t;

    csr_t csr_d, csr_q;

    logic                 step, fault, eng_active, locked;
    logic [CNT_LANES-1:0] cnt_we;
    logic [ADR_LANES-1:0] adr_we;
    logic [CNT_W-1:0]     cnt_val, cnt_new;
    logic [ADR_W-1:0]     adr_val;
    logic [CNT_LANES*8-1:0] cnt_wide;
    logic [ADR_LANES*8-1:0] adr_wide;

    assign locked = csr_q.busy | eng_active;

    always_comb begin
        for (int i = 0; i < CNT_LANES; i++)
            cnt_we[i] = reg_wr && !locked && (reg_addr == OFS_CNT + 4'(i));
        for (int i = 0; i < ADR_LANES; i++)
            adr_we[i] = reg_wr && !locked && (reg_addr == OFS_ADR + 4'(i));
        for (int b = 0; b < CNT_W; b++)
            cnt_new[b] = cnt_we[b / 8] ? reg_wdata[b % 8] : cnt_val[b];
    end

    dmx_ptr #(.W(CNT_W), .LANES(CNT_LANES), .RST(CNT_W'(1))) u_cnt (
        .clk(clk), .rst_n(rst_n), .lane_we(cnt_we), .wdata(reg_wdata),
        .inc(step), .val(cnt_val));

    dmx_ptr #(.W(ADR_W), .LANES(ADR_LANES), .RST('0)) u_adr (
        .clk(clk), .rst_n(rst_n), .lane_we(adr_we), .wdata(reg_wdata),
        .inc(step), .val(adr_val));

    dmx_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(csr_q.busy), .dir_to_mem(csr_q.ctrl[C_DIR]),
        .periph_req(periph_req), .periph_wdata(periph_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .periph_ack(periph_ack), .periph_rdata(periph_rdata),
        .step(step), .fault(fault), .active(eng_active));

    assign mem_addr = adr_val;

    // next state: software writes first, hardware events override
    always_comb begin
        csr_d = csr_q;
        if (reg_wr && reg_addr == OFS_CTRL) begin
            csr_d.ctrl   = reg_wdata;
            csr_d.mirror = reg_wdata[6:4];
            if (reg_wdata[C_RUN]) csr_d.busy = 1'b1;
        end
        if (reg_wr && reg_addr == OFS_STAT) begin
            csr_d.busy = reg_wdata[7];
            csr_d.tc   = reg_wdata[3];
            csr_d.tmo  = reg_wdata[2];
            csr_d.dint = reg_wdata[1];
            csr_d.odd  = reg_wdata[0];
        end
        if (|cnt_we && cnt_new != '0) csr_d.tc = 1'b0;
        if (step && &cnt_val) begin
            csr_d.tc          = 1'b1;
            csr_d.busy        = 1'b0;
            csr_d.ctrl[C_RUN] = 1'b0;
        end
        if (fault) begin
            csr_d.tmo         = 1'b1;
            csr_d.busy        = 1'b0;
            csr_d.ctrl[C_RUN] = 1'b0;
        end
        if (dev_int) csr_d.dint = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '{ctrl: 8'h70, mirror: 3'b111, busy: 1'b0,
                               tc: 1'b0, tmo: 1'b0, dint: 1'b0, odd: 1'b0};
        else        csr_q <= csr_d;
    end

    always_comb begin
        cnt_wide = '0;
        cnt_wide[CNT_W-1:0] = cnt_val;
        adr_wide = '0;
        adr_wide[ADR_W-1:0] = adr_val;
        reg_rdata = '0;
        if (reg_addr == OFS_STAT)
            reg_rdata = {csr_q.busy, csr_q.mirror, csr_q.tc, csr_q.tmo, csr_q.dint, csr_q.odd};
        for (int i = 0; i < CNT_LANES; i++)
            if (reg_addr == OFS_CNT + 4'(i)) reg_rdata = cnt_wide[i*8 +: 8];
        for (int i = 0; i < ADR_LANES; i++)
            if (reg_addr == OFS_ADR + 4'(i)) reg_rdata = adr_wide[i*8 +: 8];
    end

    assign irq = (csr_q.tc   & csr_q.ctrl[C_TC_IE])
               | (csr_q.tmo  & csr_q.ctrl[C_TMO_IE])
               | (csr_q.dint & csr_q.ctrl[C_DEV_IE]);

    AST_MIRROR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q.mirror == csr_q.ctrl[6:4]); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> $stable(mem_addr)); // R3

    AST_TC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && &cnt_val) |=> (!csr_q.busy && csr_q.tc && cnt_val == '0)); // R6

    AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!csr_q.busy && csr_q.tmo && $stable(cnt_val) && $stable(adr_val))); // R7

    AST_LOCKED_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !step) |=> ($stable(cnt_val) && $stable(adr_val))); // R12
endmodule

// File: tb/sim_dmx_channel.sv
`timescale 1ns/1ps
module sim_dmx_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        periph_req = 1'b0;
    logic [7:0]  periph_wdata = 8'h00;
    logic        periph_ack;
    logic [7:0]  periph_rdata;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        dev_int = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    logic [25:0] exp_q[$];
    logic        err_en = 1'b0;
    logic [17:0] err_addr = '0;
    int          lat = 0;

    always #10 clk = ~clk;

    dmx_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .periph_wdata(periph_wdata),
        .periph_ack(periph_ack), .periph_rdata(periph_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_int(dev_int), .irq(irq));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // memory model and write monitor: answers one cycle after request
    always @(negedge clk) begin
        if (mem_req) begin
            if (lat == 1) begin
                lat = 0;
                if (err_en && mem_addr == err_addr) begin
                    mem_err = 1'b1;
                end else begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem_addr[7:0] ^ 8'h5A;
                    if (mem_we) begin
                        if (exp_q.size() == 0) begin
                            chk("R3 unexpected write", {6'd0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
                        end else begin
                            logic [25:0] e;
                            e = exp_q.pop_front();
                            chk("R3 write addr/data", {6'd0, mem_addr, mem_wdata}, {6'd0, e});
                        end
                    end
                end
            end else begin
                lat = lat + 1;
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end
        end else begin
            lat = 0;
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    // one byte handshake; ok=0 when memory reported an error
    task automatic xfer(input logic [7:0] wd, output logic [7:0] rdv, output logic ok);
        @(negedge clk);
        periph_req = 1'b1; periph_wdata = wd;
        forever begin
            @(negedge clk);
            #2;
            if (periph_ack) begin ok = 1'b1; rdv = periph_rdata; break; end
            if (mem_err) begin ok = 1'b0; rdv = 8'h00; break; end
        end
        @(posedge clk);
        #1 periph_req = 1'b0;
    endtask

    task automatic push(input logic [17:0] a, input logic [7:0] d, input logic expect_ok);
        logic [7:0] r;
        logic ok;
        if (expect_ok) exp_q.push_back({a, d});
        xfer(d, r, ok);
        chk("R3 byte accepted", {31'd0, ok}, {31'd0, expect_ok});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic ok;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 status", 4'h9, 8'h70);
        rchk("R1 count lo", 4'hA, 8'h01);
        rchk("R1 count hi", 4'hB, 8'h00);
        rchk("R1 addr lo", 4'hC, 8'h00);
        rchk("R1 addr hi", 4'hD, 8'h00);
        rchk("R1 addr ext", 4'hE, 8'h00);
        rchk("R1 control reads zero", 4'h8, 8'h00);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // 3-byte write run across the 64 KiB boundary
        wr(4'hA, 8'hFD); wr(4'hB, 8'hFF);
        wr(4'hC, 8'hFE); wr(4'hD, 8'hFF); wr(4'hE, 8'h00);
        rchk("R5 count lo programmed", 4'hA, 8'hFD);
        wr(4'h8, 8'h79);
        rchk("R2 busy and mirror", 4'h9, 8'hF0);
        wr(4'hA, 8'h55);
        wr(4'hC, 8'h00);
        rchk("R12 count ignored while busy", 4'hA, 8'hFD);
        rchk("R12 addr ignored while busy", 4'hC, 8'hFE);
        push(18'h0FFFE, 8'h11, 1'b1);
        rchk("R5 live count lo", 4'hA, 8'hFE);
        rchk("R5 live addr lo", 4'hC, 8'hFF);
        push(18'h0FFFF, 8'h22, 1'b1);
        rchk("R13 addr ext carry", 4'hE, 8'h01);
        rchk("R13 addr hi after carry", 4'hD, 8'h00);
        push(18'h10000, 8'h33, 1'b1);
        rchk("R6 terminal count status", 4'h9, 8'h78);
        rchk("R6 count wrapped", 4'hA, 8'h00);
        chk("R9 irq on tc with enable", {31'd0, irq}, 32'd1);
        // R6 no further accesses
        seen = 1'b0;
        @(negedge clk) periph_req = 1'b1;
        repeat (6) begin @(negedge clk); if (mem_req) seen = 1'b1; end
        periph_req = 1'b0;
        chk("R6 no access after tc", {31'd0, seen}, 32'd0);

        // R10 status write
        wr(4'h9, 8'h00);
        rchk("R10 mirror bits kept", 4'h9, 8'h70);
        chk("R9 irq cleared", {31'd0, irq}, 32'd0);
        wr(4'h9, 8'h01);
        rchk("R10 low flag written", 4'h9, 8'h71);

        // R11
        wr(4'h9, 8'h08);
        wr(4'hA, 8'h00);
        rchk("R11 zero count keeps tc", 4'h9, 8'h78);
        wr(4'hB, 8'hFF);
        rchk("R11 nonzero count clears tc", 4'h9, 8'h70);

        // R4 memory to peripheral, no enables
        wr(4'hA, 8'hFE); wr(4'hB, 8'hFF);
        wr(4'hC, 8'h00); wr(4'hD, 8'h01); wr(4'hE, 8'h00);
        wr(4'h8, 8'h01);
        rchk("R2 run with direction 0", 4'h9, 8'h80);
        xfer(8'h00, r, ok);
        chk("R4 read byte 0", {23'd0, ok, r}, {23'd0, 1'b1, 8'h5A});
        xfer(8'h00, r, ok);
        chk("R4 read byte 1", {23'd0, ok, r}, {23'd0, 1'b1, 8'h5B});
        rchk("R6 tc after read run", 4'h9, 8'h08);
        chk("R9 irq masked tc", {31'd0, irq}, 32'd0);

        // R7 memory error on second byte
        wr(4'hA, 8'hF0); wr(4'hB, 8'hFF);
        wr(4'hC, 8'h00); wr(4'hD, 8'h02);
        err_addr = 18'h00201; err_en = 1'b1;
        wr(4'h8, 8'h15);
        rchk("R2 run with direction 1", 4'h9, 8'h90);
        push(18'h00200, 8'hAA, 1'b1);
        push(18'h00201, 8'hBB, 1'b0);
        err_en = 1'b0;
        rchk("R7 abort status", 4'h9, 8'h14);
        rchk("R7 count not advanced", 4'hA, 8'hF1);
        rchk("R7 addr not advanced", 4'hC, 8'h01);
        chk("R9 irq on fault", {31'd0, irq}, 32'd1);
        wr(4'h9, 8'h00);
        chk("R9 irq cleared after fault", {31'd0, irq}, 32'd0);

        // R8 device interrupt
        wr(4'h8, 8'h02);
        @(negedge clk) dev_int = 1'b1;
        @(negedge clk) dev_int = 1'b0;
        rchk("R8 device flag", 4'h9, 8'h02);
        chk("R9 irq on device", {31'd0, irq}, 32'd1);
        wr(4'h8, 8'h00);
        chk("R9 irq masked device", {31'd0, irq}, 32'd0);
        rchk("R8 flag kept while masked", 4'h9, 8'h02);

        chk("R3 scoreboard drained", exp_q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule